// File: doc/BRIEF.md
# Time-Sliced Banked Vector Register File

This block holds the vector registers for a fused multiply-add pipeline. It is built from storage banks that each have only one access port. There are 128 registers, and each one is a 256-bit word made of four 64-bit lanes. The low three bits of a register number pick one of eight banks, and the upper four bits pick the row inside that bank. Every access moves the whole 256-bit word at once.

A repeating four-cycle frame shares the single access path between the operand reads and the result write:

- Phase 0 reads source 1.
- Phase 1 reads source 2.
- Phase 2 reads source 3.
- Phase 3 writes a staged result.

Capture registers collect the three operands one at a time and present them together in phase 3. A separate staging register holds one incoming result until the next write phase.

Any phase that the current work leaves idle is lent to a memory port. A store reads its data from the register file in that phase, and a load writes its data in that phase. A memory request that finds no idle phase waits under a ready/valid handshake. Banks that are not touched in a cycle have their enables low, so they can be clock-gated.

Top module: `vrf_tmux_bank_rf`

## Requirements
- R1: After reset the frame is in phase 0. iss_ready is 1, mem_rvalid is 0, opnd_vld, opnd_a, opnd_b, opnd_c and bank_en are all 0, every register reads as zero, and res_ready is 1.
- R2: In any cycle at most one bit of bank_en is set. When a register is accessed, the set bit is bit reg[2:0] of that register, and the row used is reg[6:3]. When there is no access, bank_en is 0.
- R3: The frame phase advances 0, 1, 2, 3, 0, ... on every clock. iss_ready is 1 only in phase 0, and an instruction is taken only when iss_valid is high in that cycle.
- R4: An instruction taken in phase 0 reads iss_rs1 in phase 0, and reads the latched rs2 and rs3 in phases 1 and 2. In phase 3 it drives opnd_a, opnd_b and opnd_c with those values. opnd_vld bit 0 is source 1, bit 1 is source 2 and bit 2 is source 3; bits 0 and 1 are 1, and bit 2 equals iss_use3.
- R5: Operand outputs that carry no valid value are driven to zero. This covers opnd_c when iss_use3 is 0, and all operand outputs and opnd_vld in every cycle that is not the phase 3 of a frame holding an instruction.
- R6: A result is accepted when res_valid and res_ready are both 1, and is written into res_rd in the next phase 3. res_ready is 0 only while a result is staged and the phase is not 3.
- R7: After a value is written to a register, by a result or by a load, any later read of that register in a later frame returns the new value.
- R8: mem_ready is 1 exactly in idle slots: phase 0 without iss_valid; phases 1 and 2 with no instruction in the frame; phase 2 when the instruction has no third source; and phase 3 with no result staged.
- R9: A granted store (mem_wr = 0) returns the register value on mem_rdata, with mem_rvalid high for one cycle, in the cycle after the grant. A granted load (mem_wr = 1) writes mem_wdata into mem_reg.
- R10: While mem_ready is 0, a pending memory request does not access any register. It completes unchanged in a later idle slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Instruction offered at frame start |
| iss_ready | output | 1 | High in phase 0, the only phase an instruction is taken |
| iss_rs1 | input | 7 | Source 1 register number |
| iss_rs2 | input | 7 | Source 2 register number |
| iss_rs3 | input | 7 | Source 3 register number |
| iss_use3 | input | 1 | Instruction has a third source |
| opnd_a | output | 256 | Source 1 operand, presented in phase 3 |
| opnd_b | output | 256 | Source 2 operand, presented in phase 3 |
| opnd_c | output | 256 | Source 3 operand, presented in phase 3 |
| opnd_vld | output | 3 | Per-operand valid flags |
| res_valid | input | 1 | Result offered for write |
| res_ready | output | 1 | Result staging can accept |
| res_rd | input | 7 | Result destination register |
| res_data | input | 256 | Result value |
| mem_valid | input | 1 | Memory-port request |
| mem_ready | output | 1 | Current slot granted to the memory port |
| mem_wr | input | 1 | 1 = load writes the register, 0 = store reads it |
| mem_reg | input | 7 | Register number of the memory access |
| mem_wdata | input | 256 | Load data |
| mem_rdata | output | 256 | Store data read from the register |
| mem_rvalid | output | 1 | mem_rdata is valid |
| bank_en | output | 8 | Per-bank access enable, for clock gating |

## Verification
The bench targets the following cases, and what a faulty design would do in each:

- A load lands in the lent source-3 slot between the capture of source 1 and the presentation of operands. A design that captured late, or read at the wrong phase, would present the new value instead of the one read in phase 0.
- A result is staged in the same phase 3 that drains the previous one. Getting the back-pressure wrong here drops a result or writes a register twice.
- A store request is held across busy slots while the bench keeps reusing a small set of registers. A grant in a non-idle slot would show up as two bank enables or a wrong returned word.
- A register is read back in a later frame after it has been overwritten. A bank or row decoded from the wrong bits would return another register's data.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
   typedef enum logic [1:0] {
      PH_SRC1  = 2'd0,
      PH_SRC2  = 2'd1,
      PH_SRC3  = 2'd2,
      PH_WRITE = 2'd3
   } phase_e;
endpackage

// File: rtl/vrf_seq.sv
module vrf_seq
   import vrf_pkg::*;
#(
   parameter bit LEND_ONLY_SRC3 = 1'b0
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   iss_valid,
   input  logic   cur_valid,
   input  logic   cur_use3,
   input  logic   stg_full,
   output phase_e ph,
   output logic   slot_free
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ph <= PH_SRC1;
      else        ph <= phase_e'(ph + 2'd1);
   end

   generate
      if (LEND_ONLY_SRC3) begin : g_src3_only
         assign slot_free = (ph == PH_SRC3) && !cur_use3;
      end else begin : g_any_idle
         always_comb begin
            case (ph)
               PH_SRC1: slot_free = !iss_valid;
               PH_SRC2: slot_free = !cur_valid;
               PH_SRC3: slot_free = !cur_use3;
               default: slot_free = !stg_full;
            endcase
         end
      end
   endgenerate

   // R3
   ph_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_WRITE) |=> (ph == PH_SRC1));
endmodule

// File: rtl/vrf_bank.sv
module vrf_bank #(
   parameter int ROWS = 16,
   parameter int WORD = 256,
   localparam int AW = $clog2(ROWS)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic            we,
   input  logic [AW-1:0]   row,
   input  logic [WORD-1:0] wdata,
   output logic [WORD-1:0] rdata
);
   logic [WORD-1:0] mem [ROWS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ROWS; i++) mem[i] <= '0;
      end else if (en && we) begin
         mem[row] <= wdata;
      end
   end

   assign rdata = mem[row];
endmodule

// File: rtl/vrf_collect.sv
module vrf_collect
   import vrf_pkg::*;
#(
   parameter int WORD = 256
) (
   input  logic            clk,
   input  logic            rst_n,
   input  phase_e          ph,
   input  logic            iss_valid,
   input  logic            iss_use3,
   input  logic [WORD-1:0] rd_data,
   output logic            cur_valid,
   output logic            cur_use3,
   output logic [WORD-1:0] opnd_a,
   output logic [WORD-1:0] opnd_b,
   output logic [WORD-1:0] opnd_c,
   output logic [2:0]      opnd_vld
);
   logic [WORD-1:0] cap_a, cap_b, cap_c;
   logic show;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_valid <= 1'b0;
         cur_use3  <= 1'b0;
         cap_a     <= '0;
         cap_b     <= '0;
         cap_c     <= '0;
      end else begin
         case (ph)
            PH_SRC1: begin
               cur_valid <= iss_valid;
               cur_use3  <= iss_valid && iss_use3;
               if (iss_valid) cap_a <= rd_data;
            end
            PH_SRC2: if (cur_valid) cap_b <= rd_data;
            PH_SRC3: if (cur_use3)  cap_c <= rd_data;
            default: ;
         endcase
      end
   end

   assign show     = cur_valid && (ph == PH_WRITE);
   assign opnd_a   = show ? cap_a : '0;
   assign opnd_b   = show ? cap_b : '0;
   assign opnd_c   = (show && cur_use3) ? cap_c : '0;
   assign opnd_vld = show ? {cur_use3, 2'b11} : 3'b000;

   // R5
   c_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !opnd_vld[2] |-> (opnd_c == '0));
endmodule

// File: rtl/vrf_tmux_bank_rf.sv
module vrf_tmux_bank_rf
   import vrf_pkg::*;
#(
   parameter int REG_BITS  = 7,
   parameter int BANK_BITS = 3,
   parameter int LANES     = 4,
   parameter int LANE_W    = 64,
   parameter bit LEND_ONLY_SRC3 = 1'b0,
   localparam int NBANK = 1 << BANK_BITS,
   localparam int ROWS  = 1 << (REG_BITS - BANK_BITS),
   localparam int RW    = REG_BITS - BANK_BITS,
   localparam int WORD  = LANES * LANE_W
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                iss_valid,
   output logic                iss_ready,
   input  logic [REG_BITS-1:0] iss_rs1,
   input  logic [REG_BITS-1:0] iss_rs2,
   input  logic [REG_BITS-1:0] iss_rs3,
   input  logic                iss_use3,
   output logic [WORD-1:0]     opnd_a,
   output logic [WORD-1:0]     opnd_b,
   output logic [WORD-1:0]     opnd_c,
   output logic [2:0]          opnd_vld,
   input  logic                res_valid,
   output logic                res_ready,
   input  logic [REG_BITS-1:0] res_rd,
   input  logic [WORD-1:0]     res_data,
   input  logic                mem_valid,
   output logic                mem_ready,
   input  logic                mem_wr,
   input  logic [REG_BITS-1:0] mem_reg,
   input  logic [WORD-1:0]     mem_wdata,
   output logic [WORD-1:0]     mem_rdata,
   output logic                mem_rvalid,
   output logic [NBANK-1:0]    bank_en
);
   generate
      if (REG_BITS <= BANK_BITS) begin : g_bad_bits
         $error("REG_BITS must exceed BANK_BITS");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_width
         $error("LANES and LANE_W must be positive");
      end
   endgenerate

   phase_e ph;
   logic slot_free, cur_valid, cur_use3;
   logic [REG_BITS-1:0] cur_rs2, cur_rs3;
   logic stg_full;
   logic [REG_BITS-1:0] stg_rd;
   logic [WORD-1:0] stg_data;
   logic acc_en, acc_we, mem_go;
   logic [REG_BITS-1:0] acc_reg;
   logic [WORD-1:0] acc_wd, rd_data;
   logic [WORD-1:0] bank_rd [NBANK];

   vrf_seq #(.LEND_ONLY_SRC3(LEND_ONLY_SRC3)) u_seq (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid),
      .cur_valid(cur_valid), .cur_use3(cur_use3), .stg_full(stg_full),
      .ph(ph), .slot_free(slot_free)
   );

   vrf_collect #(.WORD(WORD)) u_col (
      .clk(clk), .rst_n(rst_n), .ph(ph), .iss_valid(iss_valid),
      .iss_use3(iss_use3), .rd_data(rd_data),
      .cur_valid(cur_valid), .cur_use3(cur_use3),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c), .opnd_vld(opnd_vld)
   );

   assign iss_ready = (ph == PH_SRC1);
   assign res_ready = !stg_full || (ph == PH_WRITE);
   assign mem_ready = slot_free;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_rs2 <= '0;
         cur_rs3 <= '0;
      end else if (ph == PH_SRC1 && iss_valid) begin
         cur_rs2 <= iss_rs2;
         cur_rs3 <= iss_rs3;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_full <= 1'b0;
         stg_rd   <= '0;
         stg_data <= '0;
      end else begin
         if (ph == PH_WRITE) stg_full <= 1'b0;
         if (res_valid && res_ready) begin
            stg_full <= 1'b1;
            stg_rd   <= res_rd;
            stg_data <= res_data;
         end
      end
   end

   always_comb begin
      acc_en  = 1'b0;
      acc_we  = 1'b0;
      acc_reg = iss_rs1;
      acc_wd  = stg_data;
      mem_go  = 1'b0;
      case (ph)
         PH_SRC1: acc_en = iss_valid;
         PH_SRC2: begin acc_en = cur_valid; acc_reg = cur_rs2; end
         PH_SRC3: begin acc_en = cur_use3;  acc_reg = cur_rs3; end
         default: begin
            acc_en  = stg_full;
            acc_we  = stg_full;
            acc_reg = stg_rd;
         end
      endcase
      if (mem_valid && slot_free) begin
         acc_en  = 1'b1;
         acc_we  = mem_wr;
         acc_reg = mem_reg;
         acc_wd  = mem_wdata;
         mem_go  = 1'b1;
      end
   end

   for (genvar g = 0; g < NBANK; g++) begin : g_bank
      assign bank_en[g] = acc_en && (acc_reg[BANK_BITS-1:0] == g[BANK_BITS-1:0]);
      vrf_bank #(.ROWS(ROWS), .WORD(WORD)) u_bank (
         .clk(clk), .rst_n(rst_n), .en(bank_en[g]), .we(acc_we),
         .row(acc_reg[REG_BITS-1 -: RW]), .wdata(acc_wd), .rdata(bank_rd[g])
      );
   end

   assign rd_data = acc_en ? bank_rd[acc_reg[BANK_BITS-1:0]] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_rdata  <= '0;
         mem_rvalid <= 1'b0;
      end else begin
         mem_rvalid <= mem_go && !mem_wr;
         if (mem_go && !mem_wr) mem_rdata <= rd_data;
      end
   end

   // R2
   bank_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_en));
   // R8
   mem_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_ready) |-> (bank_en == (NBANK'(1) << mem_reg[BANK_BITS-1:0])));
   // R4
   opnd_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
      opnd_vld[0] |-> $past(iss_valid && iss_ready, 3));
   // R9
   rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mem_rvalid |-> $past(mem_valid && mem_ready && !mem_wr));
   // R3
   issue_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      iss_ready |=> !iss_ready);
endmodule

// File: tb/vrf_tmux_bank_rf_bench.sv
module vrf_tmux_bank_rf_bench;
   localparam int CLK_PERIOD = 10;
   localparam int W = 256;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic iss_valid = 0, iss_use3 = 0;
   logic [6:0] iss_rs1 = 0, iss_rs2 = 0, iss_rs3 = 0;
   logic res_valid = 0;
   logic [6:0] res_rd = 0;
   logic [W-1:0] res_data = '0;
   logic mem_valid = 0, mem_wr = 0;
   logic [6:0] mem_reg = 0;
   logic [W-1:0] mem_wdata = '0;
   logic iss_ready, res_ready, mem_ready, mem_rvalid;
   logic [W-1:0] opnd_a, opnd_b, opnd_c, mem_rdata;
   logic [2:0] opnd_vld;
   logic [7:0] bank_en;

   int checks = 0, errors = 0;

   vrf_tmux_bank_rf u_vrf_tmux_bank_rf (
      .clk(clk), .rst_n(rst_n),
      .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_rs1(iss_rs1),
      .iss_rs2(iss_rs2), .iss_rs3(iss_rs3), .iss_use3(iss_use3),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .opnd_c(opnd_c), .opnd_vld(opnd_vld),
      .res_valid(res_valid), .res_ready(res_ready), .res_rd(res_rd), .res_data(res_data),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_wr(mem_wr), .mem_reg(mem_reg),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid),
      .bank_en(bank_en)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // behavioural reference state
   int ph = 0;
   logic [W-1:0] regs [128];
   logic m_cv = 0, m_u3 = 0, m_stg = 0, m_rv = 0;
   logic [6:0] m_rs2 = 0, m_rs3 = 0, m_stg_rd = 0;
   logic [W-1:0] m_a = '0, m_b = '0, m_c = '0, m_stg_d = '0, m_rd = '0;
   logic mgrant = 0, rgrant = 0;
   bit live = 0;

   initial for (int i = 0; i < 128; i++) regs[i] = '0;

   task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic idle_slot();
      case (ph)
         0: return !iss_valid;
         1: return !m_cv;
         2: return !m_u3;
         default: return !m_stg;
      endcase
   endfunction

   function automatic logic [7:0] exp_banks();
      logic [6:0] r;
      logic en;
      en = 1'b0; r = '0;
      if (mem_valid && idle_slot()) begin en = 1'b1; r = mem_reg; end
      else case (ph)
         0: begin en = iss_valid; r = iss_rs1; end
         1: begin en = m_cv; r = m_rs2; end
         2: begin en = m_u3; r = m_rs3; end
         default: begin en = m_stg; r = m_stg_rd; end
      endcase
      return en ? (8'd1 << r[2:0]) : 8'd0;
   endfunction

   // model update at the active edge
   always @(posedge clk) begin
      if (!rst_n) begin
         ph = 0; m_cv = 0; m_u3 = 0; m_stg = 0; m_rv = 0;
         mgrant = 0; rgrant = 0;
      end else begin
         logic free, rr;
         free = idle_slot();
         rr = !m_stg || ph == 3;
         mgrant = mem_valid && free;
         rgrant = res_valid && rr;
         case (ph)
            0: begin
               m_cv = iss_valid; m_u3 = iss_valid && iss_use3;
               if (iss_valid) begin
                  m_a = regs[iss_rs1]; m_rs2 = iss_rs2; m_rs3 = iss_rs3;
               end
            end
            1: if (m_cv) m_b = regs[m_rs2];
            2: if (m_u3) m_c = regs[m_rs3];
            default: if (m_stg) begin regs[m_stg_rd] = m_stg_d; m_stg = 0; end
         endcase
         if (rgrant) begin m_stg = 1; m_stg_rd = res_rd; m_stg_d = res_data; end
         m_rv = mgrant && !mem_wr;
         if (mgrant && !mem_wr) m_rd = regs[mem_reg];
         if (mgrant && mem_wr) regs[mem_reg] = mem_wdata;
         ph = (ph + 1) % 4;
      end
   end

   // compare away from the active edge
   always @(negedge clk) begin
      if (rst_n && live) begin
         logic show;
         show = m_cv && ph == 3;
         chk("R3 iss_ready", W'(iss_ready), W'(ph == 0));
         chk("R2 bank_en", W'(bank_en), W'(exp_banks()));
         chk("R8/R10 mem_ready", W'(mem_ready), W'(idle_slot()));
         chk("R6 res_ready", W'(res_ready), W'(!m_stg || ph == 3));
         // R4 and R7: operands carry the latest written values
         chk("R4 opnd_a", opnd_a, show ? m_a : '0);
         chk("R4 opnd_b", opnd_b, show ? m_b : '0);
         chk("R5 opnd_c", opnd_c, (show && m_u3) ? m_c : '0);
         chk("R5 opnd_vld", W'(opnd_vld), show ? W'({m_u3, 2'b11}) : '0);
         chk("R9 mem_rvalid", W'(mem_rvalid), W'(m_rv));
         if (m_rv) chk("R9 mem_rdata", mem_rdata, m_rd);
      end
   end

   function automatic logic [W-1:0] rnd_word();
      logic [W-1:0] v;
      for (int k = 0; k < W/32; k++) v[k*32 +: 32] = $urandom;
      return v;
   endfunction

   function automatic logic [6:0] pick(input int mask);
      return 7'($urandom) & 7'(mask);
   endfunction

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : stim
      void'($urandom(32'h5eed));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 iss_ready", W'(iss_ready), W'(1));
      chk("R1 res_ready", W'(res_ready), W'(1));
      chk("R1 mem_rvalid", W'(mem_rvalid), '0);
      chk("R1 opnd_vld", W'(opnd_vld), '0);
      chk("R1 opnd_a", opnd_a, '0);
      chk("R1 bank_en", W'(bank_en), '0);
      live = 1;
      for (int seg = 0; seg < 4; seg++) begin
         int mask, p_iss, p_mem, p_res;
         mask  = (seg == 3) ? 7'h13 : 7'h7f;
         p_iss = (seg == 0) ? 20 : (seg == 2 ? 90 : 50);
         p_mem = (seg == 1) ? 90 : 40;
         p_res = (seg == 0) ? 60 : 40;
         for (int c = 0; c < 1500; c++) begin
            @(posedge clk);
            #1;
            iss_valid = ($urandom % 100) < p_iss;
            iss_use3  = (seg == 2) ? 1'b1 : $urandom % 2;
            iss_rs1 = pick(mask); iss_rs2 = pick(mask); iss_rs3 = pick(mask);
            // R10: an ungranted request holds its fields
            if (!(mem_valid && !mgrant)) begin
               mem_valid = ($urandom % 100) < p_mem;
               mem_wr = $urandom % 2;
               mem_reg = pick(mask);
               mem_wdata = rnd_word();
            end
            // R6: an ungranted result holds its fields
            if (!(res_valid && !rgrant)) begin
               res_valid = ($urandom % 100) < p_res;
               res_rd = pick(mask);
               res_data = rnd_word();
            end
         end
      end
      @(posedge clk);
      #1 iss_valid = 0; mem_valid = 0; res_valid = 0;
      repeat (8) @(posedge clk);
      @(negedge clk);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule